// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Elevation

This block picks one interrupt to hand to the CPU. It chooses among a fixed, ordered list of maskable requests and three non-maskable sources. The maskable requests are an external active-low IRQ pin and a parameterized set of peripheral flag/enable pairs. The non-maskable sources are an illegal-opcode trap, a software interrupt and an external active-low XIRQ pin. Each source owns a two-byte vector in the top page of memory, so the controller reports the winner as a 16-bit address whose upper byte is always 0xFF.

A single priority-select register can move any one maskable source to the head of the maskable order. Software names the source by writing the low byte of its vector. The register accepts a write only while the CPU's global I mask is set. The arbitration result is captured in registers only on an instruction-boundary strobe from the CPU. It is then held until the next strobe, or until the CPU acknowledges it.

Top module: `intc_top`

## Requirements
- R1: The non-maskable sources outrank every maskable source, in the fixed order trap (low byte 0xF8), then software interrupt (0xF6), then XIRQ (0xF4). The priority-select register does not change this.
- R2: The X mask input blocks only XIRQ. The trap and the software interrupt are still granted while X is set, and so are maskable sources.
- R3: A peripheral requests only when both its flag and its enable are 1. No maskable source is granted while the I mask is 1.
- R4: The default maskable order is the IRQ pin first (low byte 0xF2), then peripheral k (k = 1..N_PER, flag/enable bit k-1) at low byte 0xF2 - 2k. A lower k wins.
- R5: A maskable source whose vector low byte, bits 7:1, equals the priority-select register wins over all other maskable sources. It still ranks below the non-maskable sources.
- R6: A priority-select write is stored only while the I mask is 1, and a write made with I at 0 has no effect. Bit 0 of the written byte is ignored.
- R7: After reset the priority-select register holds 0xDE, which elevates peripheral 10, the timer-overflow source.
- R8: If the priority-select value matches no implemented source, the default order of R4 is used.
- R9: With the IRQ mode input at 0, the IRQ pin requests while it is low.
- R10: With the IRQ mode input at 1, a falling edge on the IRQ pin is latched and keeps requesting after the pin returns high. The latch clears when the CPU acknowledges a presented 0xF2 vector.
- R11: The request output and the vector are loaded only on a cycle with the boundary strobe high and otherwise hold their value. After reset the request is 0 and the vector is 0xFF00. The vector's upper byte is 0xFF.
- R12: An acknowledge clears the request output at the next edge and takes precedence over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_flag_i | input | N_PER | Peripheral event flags, bit k-1 for peripheral k |
| per_en_i | input | N_PER | Peripheral local enables |
| irq_n_i | input | 1 | External maskable request pin, active low |
| irq_edge_i | input | 1 | 1: IRQ pin is falling-edge sensitive; 0: IRQ pin is low-level sensitive |
| xirq_n_i | input | 1 | External non-maskable request pin, active low |
| swi_i | input | 1 | Software interrupt request |
| trap_i | input | 1 | Illegal-opcode trap request |
| imask_i | input | 1 | CPU global maskable-interrupt mask (I) |
| xmask_i | input | 1 | CPU XIRQ mask (X) |
| psel_wr_i | input | 1 | Write strobe for the priority-select register |
| psel_wdata_i | input | 8 | Vector low byte to elevate |
| bnd_i | input | 1 | Instruction-boundary strobe |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| req_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector address of the presented interrupt |

## Verification
The request and vector change one rising edge after the cycle in which the boundary strobe is high, and one edge after an acknowledge. A falling IRQ edge in edge mode takes one extra edge to reach the latch before a strobe can see it, and a priority-select write takes one edge to be stored. The bench therefore changes inputs at the falling clock edge and holds the strobe, write or acknowledge for exactly one cycle. It reads the outputs at the next falling edge, so every sample falls one register stage after its cause. The hold check changes inputs with no strobe and waits two edges before sampling, to show that nothing moved.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam logic [7:0] VEC_PAGE = 8'hFF;
  localparam logic [7:0] LO_TRAP  = 8'hF8;
  localparam logic [7:0] LO_SWI   = 8'hF6;
  localparam logic [7:0] LO_XIRQ  = 8'hF4;
  localparam logic [7:0] LO_IRQ   = 8'hF2;
  localparam logic [6:0] PSEL_RST = 7'h6F;   // byte 0xDE with bit 0 dropped

  // maskable index 0 is the IRQ pin, index k is peripheral k
  function automatic logic [7:0] msk_lo(input int idx);
    return LO_IRQ - 8'(2 * idx);
  endfunction
endpackage

// File: rtl/intc_psel.sv
module intc_psel
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [6:0] wsel_i,
  input  logic       imask_i,
  output logic [6:0] psel_o
);
  logic [6:0] psel_q, psel_d;
  logic       load;

  assign load = wr_i & imask_i;

  always_comb begin
    psel_d = psel_q;
    if (load) psel_d = wsel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psel_q <= PSEL_RST;
    else        psel_q <= psel_d;
  end

  assign psel_o = psel_q;

  AST_PSEL_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !imask_i) |=> (psel_o == $past(psel_o))); // R6
  AST_PSEL_WR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && imask_i) |=> (psel_o == $past(wsel_i))); // R6
endmodule

// File: rtl/intc_irq_pin.sv
module intc_irq_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic ack_i,
  output logic pend_o
);
  logic prev_q;
  logic latch_q, latch_d;
  logic fall;

  assign fall = prev_q & ~pin_n_i;

  always_comb begin
    latch_d = 1'b0;
    if (edge_mode_i) latch_d = (latch_q & ~ack_i) | fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= pin_n_i;
      latch_q <= latch_d;
    end
  end

  assign pend_o = edge_mode_i ? latch_q : ~pin_n_i;

  AST_IRQ_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && prev_q && !pin_n_i) |=> latch_q); // R10
  AST_IRQ_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && ack_i && !(prev_q && !pin_n_i)) |=> !latch_q); // R10
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int N_MSK = 13,
  localparam int IW = $clog2(N_MSK)
) (
  input  logic [N_MSK-1:0] mreq_i,
  input  logic [6:0]       psel_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o
);
  logic [N_MSK-1:0] match;

  for (genvar g = 0; g < N_MSK; g++) begin : g_match
    localparam logic [7:0] LO = msk_lo(g);
    assign match[g] = (LO[7:1] == psel_i);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_MSK - 1; i >= 0; i--) begin
      if (mreq_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
    for (int i = 0; i < N_MSK; i++) begin
      if (mreq_i[i] && match[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int N_PER = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PER-1:0] per_flag_i,
  input  logic [N_PER-1:0] per_en_i,
  input  logic             irq_n_i,
  input  logic             irq_edge_i,
  input  logic             xirq_n_i,
  input  logic             swi_i,
  input  logic             trap_i,
  input  logic             imask_i,
  input  logic             xmask_i,
  input  logic             psel_wr_i,
  input  logic [7:0]       psel_wdata_i,
  input  logic             bnd_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [15:0]      vec_o
);
  localparam int N_MSK = N_PER + 1;
  localparam int IW    = $clog2(N_MSK);

  logic [6:0]       psel;
  logic             irq_pend;
  logic             ack_irq;
  logic [N_MSK-1:0] mreq;
  logic             arb_hit;
  logic [IW-1:0]    arb_idx;
  logic             xirq_act;
  logic             win_any;
  logic [7:0]       win_lo;
  logic             req_q, req_d;
  logic [7:0]       lo_q, lo_d;
  logic             wdata_unused;

  assign wdata_unused = psel_wdata_i[0];

  intc_psel u_psel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (psel_wr_i),
    .wsel_i  (psel_wdata_i[7:1]),
    .imask_i (imask_i),
    .psel_o  (psel)
  );

  assign ack_irq = ack_i & req_q & (lo_q == LO_IRQ);

  intc_irq_pin u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_n_i     (irq_n_i),
    .edge_mode_i (irq_edge_i),
    .ack_i       (ack_irq),
    .pend_o      (irq_pend)
  );

  assign mreq = {per_flag_i & per_en_i, irq_pend} & {N_MSK{~imask_i}};

  intc_arb #(.N_MSK(N_MSK)) u_arb (
    .mreq_i (mreq),
    .psel_i (psel),
    .hit_o  (arb_hit),
    .idx_o  (arb_idx)
  );

  assign xirq_act = ~xirq_n_i & ~xmask_i;

  always_comb begin
    win_any = 1'b1;
    win_lo  = 8'h00;
    if (trap_i)        win_lo = LO_TRAP;
    else if (swi_i)    win_lo = LO_SWI;
    else if (xirq_act) win_lo = LO_XIRQ;
    else if (arb_hit)  win_lo = msk_lo(int'(arb_idx));
    else               win_any = 1'b0;
  end

  always_comb begin
    req_d = req_q;
    lo_d  = lo_q;
    if (ack_i) begin
      req_d = 1'b0;
    end else if (bnd_i) begin
      req_d = win_any;
      lo_d  = win_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lo_q  <= 8'h00;
    end else begin
      req_q <= req_d;
      lo_q  <= lo_d;
    end
  end

  assign req_o = req_q;
  assign vec_o = {VEC_PAGE, lo_q};

  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_i && !ack_i && trap_i) |=> (req_o && vec_o[7:0] == LO_TRAP)); // R1
  AST_SWI_IGNORES_X: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_i && !ack_i && !trap_i && swi_i) |=> (req_o && vec_o[7:0] == LO_SWI)); // R2
  AST_IMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_i && !ack_i && imask_i && !trap_i && !swi_i && (xmask_i || xirq_n_i))
      |=> !req_o); // R3
  AST_HOLD_OFF_BND: assert property (@(posedge clk) disable iff (!rst_n)
    (!bnd_i && !ack_i) |=> ($stable(req_o) && $stable(vec_o))); // R11
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !req_o); // R12
  AST_PAGE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o[15:8] == 8'hFF); // R11
endmodule

// File: tb/tb_intc_top.sv
module tb_intc_top;
  localparam int NP = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] per_flag, per_en;
  logic          irq_n, irq_edge, xirq_n, swi, trap, imask, xmask;
  logic          psel_wr, bnd, ack;
  logic [7:0]    psel_wdata;
  logic          req;
  logic [15:0]   vec;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  intc_top #(.N_PER(NP)) dut (
    .clk(clk), .rst_n(rst_n), .per_flag_i(per_flag), .per_en_i(per_en),
    .irq_n_i(irq_n), .irq_edge_i(irq_edge), .xirq_n_i(xirq_n), .swi_i(swi),
    .trap_i(trap), .imask_i(imask), .xmask_i(xmask), .psel_wr_i(psel_wr),
    .psel_wdata_i(psel_wdata), .bnd_i(bnd), .ack_i(ack), .req_o(req), .vec_o(vec)
  );

  typedef struct packed {
    logic [NP-1:0] flag;
    logic [NP-1:0] en;
    logic          irq_n;
    logic          xirq_n;
    logic          swi;
    logic          trap;
    logic          imask;
    logic          xmask;
    logic          exp_req;
    logic [7:0]    exp_lo;
  } row_t;

  localparam int NROW = 13;
  localparam row_t TBL [NROW] = '{
    '{12'h000, 12'h000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 idle
    '{12'h001, 12'h001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hF0}, // R4 p1
    '{12'h001, 12'h000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 no enable
    '{12'h001, 12'h001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R3 I set
    '{12'h014, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hEC}, // R4 p3 over p5
    '{12'h204, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hDE}, // R7 p10 elevated
    '{12'h001, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hF2}, // R9 level IRQ
    '{12'h200, 12'h200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hF4}, // R1 XIRQ
    '{12'h001, 12'h001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hF0}, // R2 X blocks XIRQ
    '{12'h000, 12'h000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hF6}, // R2 SWI with X
    '{12'h000, 12'h000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hF8}, // R1 trap
    '{12'h200, 12'h200, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hF6}, // R1 SWI
    '{12'h200, 12'h200, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hDE}  // R5 over IRQ
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    per_flag = '0; per_en = '0; irq_n = 1'b1; xirq_n = 1'b1;
    swi = 1'b0; trap = 1'b0; imask = 1'b0; xmask = 1'b0;
  endtask

  task automatic strobe();
    bnd = 1'b1;
    @(negedge clk);
    bnd = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic write_psel(input logic [7:0] d);
    psel_wr = 1'b1; psel_wdata = d;
    @(negedge clk);
    psel_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle_inputs(); irq_edge = 1'b0;
    psel_wr = 1'b0; psel_wdata = 8'h00; bnd = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset req", {15'd0, req}, 16'd0);
    check("R11 reset vec", vec, 16'hFF00);

    for (int r = 0; r < NROW; r++) begin
      per_flag = TBL[r].flag; per_en = TBL[r].en;
      irq_n = TBL[r].irq_n; xirq_n = TBL[r].xirq_n;
      swi = TBL[r].swi; trap = TBL[r].trap;
      imask = TBL[r].imask; xmask = TBL[r].xmask;
      strobe();
      check($sformatf("table row %0d req (R1-R9 set)", r), {15'd0, req}, {15'd0, TBL[r].exp_req});
      if (TBL[r].exp_req)
        check($sformatf("table row %0d vec", r), vec, {8'hFF, TBL[r].exp_lo});
    end

    // R6: write with I clear is dropped, p10 stays elevated
    idle_inputs();
    write_psel(8'hF0);
    per_flag = 12'h201; per_en = 12'h201;
    strobe();
    check("R6 write with I clear ignored", vec, 16'hFFDE);

    // R6 and R5: write with I set, bit 0 set, elevates p5 (0xE8)
    imask = 1'b1;
    write_psel(8'hE9);
    imask = 1'b0;
    per_flag = 12'h011; per_en = 12'hFFF;
    strobe();
    check("R5 R6 p5 elevated", vec, 16'hFFE8);

    // R8: unmatched select falls back to default order
    imask = 1'b1;
    write_psel(8'h20);
    imask = 1'b0;
    per_flag = 12'h204; per_en = 12'hFFF;
    strobe();
    check("R8 default order p3", vec, 16'hFFEC);

    // R11: no strobe means no change
    per_flag = 12'h001; per_en = 12'h001;
    strobe();
    check("R11 present p1", vec, 16'hFFF0);
    per_flag = 12'h000; trap = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 hold vec", vec, 16'hFFF0);
    check("R11 hold req", {15'd0, req}, 16'd1);
    trap = 1'b0;

    // R12: acknowledge clears, and beats a strobe in the same cycle
    per_flag = 12'h001;
    ack = 1'b1; bnd = 1'b1;
    @(negedge clk);
    ack = 1'b0; bnd = 1'b0;
    check("R12 ack clears req", {15'd0, req}, 16'd0);

    // R10: falling edge is latched, cleared on ack of 0xF2
    idle_inputs();
    irq_edge = 1'b1;
    @(negedge clk);
    irq_n = 1'b0;
    @(negedge clk);
    irq_n = 1'b1;
    @(negedge clk);
    strobe();
    check("R10 edge latched req", {15'd0, req}, 16'd1);
    check("R10 edge latched vec", vec, 16'hFFF2);
    pulse_ack();
    strobe();
    check("R10 latch cleared by ack", {15'd0, req}, 16'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule